// File: doc/BRIEF.md
# Virtual Screen Geometry and Panning Start Address Unit

This unit keeps the layout of a virtual frame buffer that may be wider than the visible picture. When software proposes a new virtual width, the unit derives the bytes per scan line from the current pixel depth. It divides the memory size by that line length to get the number of lines that fit, which is the virtual height. It commits the new geometry only if the width covers the visible width and the height covers the visible height. The division is iterative, so a width update takes several cycles. During that time the unit reports busy, and any further write is refused with a stall.

Horizontal and vertical panning offsets are written separately. Each offset write recomputes the display start address, expressed in 32-bit words, from the committed line length and the current depth. The visible resolution, the depth and the memory size are held by neighbouring logic and arrive as plain inputs.

The control sequencer has three states. `ST_IDLE` accepts writes. `ST_DIVIDE` waits for the divider. `ST_FINISH` holds the verdict for one cycle and commits an accepted geometry. The transitions are:
- `ST_IDLE` to `ST_DIVIDE` on a width write that passes the pre-checks.
- `ST_IDLE` to `ST_FINISH` on a width write that fails them.
- `ST_DIVIDE` to `ST_FINISH` when the divider stops running.
- `ST_FINISH` to `ST_IDLE` always.

Top module: `geo_calc`

## Requirements
- R1: After reset, virt_width, virt_height, line_bytes and start_word are 0, and busy, done and stall are low.
- R2: Write target codes on wr_sel are: 0 for virtual width, 1 for X offset, 2 for Y offset. Code 3 is ignored. Line bytes are width/2 (truncated) when depth is 4. At any other depth they are width × floor((depth+7)/8).
- R3: An accepted virtual height is floor(mem_bytes / line_bytes).
- R4: A width below hres is rejected. done pulses with geo_ok low, and virt_width, virt_height and line_bytes keep their values.
- R5: A width whose derived height is below vres is rejected, and none of virt_width, virt_height or line_bytes changes.
- R6: On acceptance, virt_width, virt_height and line_bytes all change on the clock edge that ends the single done cycle, and at no other time.
- R7: A write to X or Y sets start_word, on the same edge, to (line_bytes × Y + Xbytes) >> 2. Xbytes is X/2 at depth 4 and X × floor((depth+7)/8) otherwise. line_bytes is the committed value.
- R8: busy is high from the edge after a width write until the done cycle ends. A write presented while busy raises stall in the same cycle and is ignored.
- R9: A width whose line length is zero is rejected.
- R10: done is raised no later than MW+2 cycles after the width write is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target code (R2) |
| wr_data | input | DW | Write value |
| hres | input | DW | Visible width in pixels |
| vres | input | DW | Visible height in lines |
| depth | input | 6 | Bits per pixel (4, 8, 15, 16, 24, 32) |
| mem_bytes | input | MW | Frame memory size in bytes |
| stall | output | 1 | Write refused because busy |
| busy | output | 1 | Width check in progress |
| done | output | 1 | One-cycle verdict strobe |
| geo_ok | output | 1 | Width accepted, valid with done |
| virt_width | output | DW | Committed virtual width |
| virt_height | output | MW | Committed virtual height |
| line_bytes | output | DW+2 | Committed bytes per scan line |
| start_word | output | 2*DW+1 | Display start address in 32-bit words |

## Verification
The assertions assume that hres, vres, depth and mem_bytes are held steady from a width write until its done cycle. The height comparison and the width bound refer to the values sampled one cycle earlier. The bench therefore changes these inputs only while busy is low, and only on falling edges between commands. It also uses only the six legal depths.

// File: rtl/geo_pkg.sv
package geo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIVIDE = 2'd1,
        ST_FINISH = 2'd2
    } geo_state_t;

    typedef enum logic [1:0] {
        SEL_VWIDTH = 2'd0,
        SEL_XOFF   = 2'd1,
        SEL_YOFF   = 2'd2,
        SEL_NONE   = 2'd3
    } geo_sel_t;

endpackage

// File: rtl/geo_scale.sv
// Converts a pixel count into a byte count for a given depth.
module geo_scale #(
    parameter int DW = 16,
    parameter int LW = DW + 2
) (
    input  logic [DW-1:0] pixels,
    input  logic [5:0]    depth,
    output logic [LW-1:0] bytes
);
    logic [6:0] depth_round;
    logic [3:0] per_pixel;

    always_comb begin
        depth_round = {1'b0, depth} + 7'd7;
        per_pixel   = 4'(depth_round >> 3);
        if (depth == 6'd4)
            bytes = LW'(pixels >> 1);
        else
            bytes = LW'(pixels) * LW'(per_pixel);
    end
endmodule

// File: rtl/geo_divider.sv
// Restoring divider, one quotient bit per cycle.
module geo_divider #(
    parameter int NW = 24,
    parameter int QW = 18,
    localparam int CW = $clog2(NW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] dividend,
    input  logic [QW-1:0] divisor,
    output logic          running,
    output logic [NW-1:0] quotient
);
    logic [QW-1:0] rem_q;
    logic [NW-1:0] dvd_q;
    logic [NW-1:0] quo_q;
    logic [QW-1:0] dsr_q;
    logic [CW-1:0] cnt_q;
    logic [QW:0]   trial;
    logic [QW:0]   diff;

    always_comb begin
        trial = {rem_q, dvd_q[NW-1]};
        diff  = trial - {1'b0, dsr_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            dvd_q <= '0;
            quo_q <= '0;
            dsr_q <= '0;
            cnt_q <= '0;
        end else if (start) begin
            rem_q <= '0;
            dvd_q <= dividend;
            quo_q <= '0;
            dsr_q <= divisor;
            cnt_q <= CW'(NW);
        end else if (cnt_q != '0) begin
            dvd_q <= dvd_q << 1;
            cnt_q <= cnt_q - 1'b1;
            if (trial >= {1'b0, dsr_q}) begin
                rem_q <= diff[QW-1:0];
                quo_q <= {quo_q[NW-2:0], 1'b1};
            end else begin
                rem_q <= trial[QW-1:0];
                quo_q <= {quo_q[NW-2:0], 1'b0};
            end
        end
    end

    assign running  = (cnt_q != '0);
    assign quotient = quo_q;
endmodule

// File: rtl/geo_pan.sv
// Holds panning offsets and the display start address.
module geo_pan #(
    parameter int DW = 16,
    parameter int LW = DW + 2,
    localparam int SUMW = LW + DW + 1,
    localparam int SW = SUMW - 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          load_x,
    input  logic [DW-1:0] data,
    input  logic [5:0]    depth,
    input  logic [LW-1:0] line_bytes,
    output logic [SW-1:0] start_word
);
    logic [DW-1:0]   xoff_q, yoff_q;
    logic [DW-1:0]   x_next, y_next;
    logic [LW-1:0]   x_bytes;
    logic [SUMW-1:0] sum;
    logic [SW-1:0]   start_q;

    always_comb begin
        x_next = (load && load_x)  ? data : xoff_q;
        y_next = (load && !load_x) ? data : yoff_q;
    end

    geo_scale #(.DW(DW), .LW(LW)) u_xscale (
        .pixels (x_next),
        .depth  (depth),
        .bytes  (x_bytes)
    );

    always_comb sum = SUMW'(line_bytes) * SUMW'(y_next) + SUMW'(x_bytes);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xoff_q  <= '0;
            yoff_q  <= '0;
            start_q <= '0;
        end else if (load) begin
            xoff_q  <= x_next;
            yoff_q  <= y_next;
            start_q <= SW'(sum >> 2);
        end
    end

    assign start_word = start_q;
endmodule

// File: rtl/geo_calc.sv
module geo_calc
    import geo_pkg::*;
#(
    parameter int DW = 16,
    parameter int MW = 24,
    localparam int LW = DW + 2,
    localparam int SW = LW + DW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] hres,
    input  logic [DW-1:0] vres,
    input  logic [5:0]    depth,
    input  logic [MW-1:0] mem_bytes,
    output logic          stall,
    output logic          busy,
    output logic          done,
    output logic          geo_ok,
    output logic [DW-1:0] virt_width,
    output logic [MW-1:0] virt_height,
    output logic [LW-1:0] line_bytes,
    output logic [SW-1:0] start_word
);
    geo_state_t    state_q, state_n;
    logic          idle_wr, width_wr, pan_wr;
    logic [LW-1:0] cand_line;
    logic          pre_ok;
    logic          div_start, div_running;
    logic [MW-1:0] div_quot;
    logic [DW-1:0] cand_w_q;
    logic [LW-1:0] cand_l_q;
    logic          pre_fail_q;
    logic          fin_ok;
    logic [DW-1:0] vw_q;
    logic [MW-1:0] vh_q;
    logic [LW-1:0] lb_q;

    // write decode
    always_comb begin
        idle_wr  = wr_en && (state_q == ST_IDLE);
        width_wr = idle_wr && (wr_sel == SEL_VWIDTH);
        pan_wr   = idle_wr && ((wr_sel == SEL_XOFF) || (wr_sel == SEL_YOFF));
    end

    geo_scale #(.DW(DW), .LW(LW)) u_lscale (
        .pixels (wr_data),
        .depth  (depth),
        .bytes  (cand_line)
    );

    always_comb begin
        pre_ok    = (wr_data >= hres) && (cand_line != '0);
        div_start = width_wr && pre_ok;
    end

    geo_divider #(.NW(MW), .QW(LW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (mem_bytes),
        .divisor  (cand_line),
        .running  (div_running),
        .quotient (div_quot)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_n;
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (width_wr)
                    state_n = pre_ok ? ST_DIVIDE : ST_FINISH;
            end
            ST_DIVIDE: begin
                if (!div_running)
                    state_n = ST_FINISH;
            end
            ST_FINISH: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // verdict
    always_comb fin_ok = !pre_fail_q && (div_quot >= {{(MW-DW){1'b0}}, vres});

    // candidate capture and commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_w_q   <= '0;
            cand_l_q   <= '0;
            pre_fail_q <= 1'b0;
            vw_q       <= '0;
            vh_q       <= '0;
            lb_q       <= '0;
        end else begin
            if (width_wr) begin
                cand_w_q   <= wr_data;
                cand_l_q   <= cand_line;
                pre_fail_q <= !pre_ok;
            end
            if (state_q == ST_FINISH && fin_ok) begin
                vw_q <= cand_w_q;
                vh_q <= div_quot;
                lb_q <= cand_l_q;
            end
        end
    end

    geo_pan #(.DW(DW), .LW(LW)) u_pan (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (pan_wr),
        .load_x     (wr_sel == SEL_XOFF),
        .data       (wr_data),
        .depth      (depth),
        .line_bytes (lb_q),
        .start_word (start_word)
    );

    // outputs
    always_comb begin
        busy        = (state_q != ST_IDLE);
        done        = (state_q == ST_FINISH);
        geo_ok      = done && fin_ok;
        stall       = wr_en && busy;
        virt_width  = vw_q;
        virt_height = vh_q;
        line_bytes  = lb_q;
    end
endmodule

// File: rtl/geo_calc_chk.sv
module geo_calc_chk #(
    parameter int DW = 16,
    parameter int MW = 24,
    localparam int LW = DW + 2,
    localparam int SW = LW + DW - 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          busy,
    input logic          done,
    input logic          geo_ok,
    input logic [DW-1:0] hres,
    input logic [DW-1:0] vres,
    input logic [DW-1:0] virt_width,
    input logic [MW-1:0] virt_height,
    input logic [LW-1:0] line_bytes,
    input logic [SW-1:0] start_word
);
    assert_stall_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> $stable(start_word));

    assert_busy_from_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en));

    assert_reject_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !geo_ok) |=> ($stable(virt_width) && $stable(virt_height) && $stable(line_bytes)));

    assert_width_covers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && geo_ok) |=> (virt_width >= $past(hres)));

    assert_height_covers_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && geo_ok) |=> (virt_height >= {{(MW-DW){1'b0}}, $past(vres)}));

    assert_commit_only_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(virt_width) && $stable(virt_height) && $stable(line_bytes)));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_line_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && geo_ok) |=> (line_bytes != '0));
endmodule

bind geo_calc geo_calc_chk #(.DW(DW), .MW(MW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .busy        (busy),
    .done        (done),
    .geo_ok      (geo_ok),
    .hres        (hres),
    .vres        (vres),
    .virt_width  (virt_width),
    .virt_height (virt_height),
    .line_bytes  (line_bytes),
    .start_word  (start_word)
);

// File: tb/sim_geo_calc.sv
module sim_geo_calc;
    localparam int DW = 16;
    localparam int MW = 24;
    localparam int LW = DW + 2;
    localparam int SW = LW + DW - 1;
    localparam longint MEM = 64'h100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] hres = 16'd640;
    logic [DW-1:0] vres = 16'd300;
    logic [5:0]    depth = 6'd8;
    logic [MW-1:0] mem_bytes = MW'(MEM);
    logic          stall, busy, done, geo_ok;
    logic [DW-1:0] virt_width;
    logic [MW-1:0] virt_height;
    logic [LW-1:0] line_bytes;
    logic [SW-1:0] start_word;

    int checks = 0;
    int errors = 0;
    bit ended = 0;

    geo_calc #(.DW(DW), .MW(MW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .hres(hres), .vres(vres), .depth(depth), .mem_bytes(mem_bytes),
        .stall(stall), .busy(busy), .done(done), .geo_ok(geo_ok),
        .virt_width(virt_width), .virt_height(virt_height),
        .line_bytes(line_bytes), .start_word(start_word)
    );

    always #10 clk = ~clk;

    function automatic longint ref_bytes(longint px, int d);
        if (d == 4) return px / 2;
        return px * ((d + 7) / 8);
    endfunction

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // one-cycle write; returns at the falling edge after the sampling edge
    task automatic wr(logic [1:0] sel, logic [DW-1:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // waits for done, checks latency (R10), returns at falling edge after commit
    task automatic wait_done(output logic ok);
        int n = 1;
        while (!done && n < MW + 10) begin
            @(negedge clk);
            n++;
        end
        chk("R10 done latency bound", (n <= MW + 2) ? 1 : 0, 1);
        ok = geo_ok;
        @(negedge clk);
        chk("R6 done single pulse", done, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset virt_width", virt_width, 0);
        chk("R1 reset virt_height", virt_height, 0);
        chk("R1 reset line_bytes", line_bytes, 0);
        chk("R1 reset start_word", start_word, 0);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_depths();
        int dl[6] = '{4, 8, 15, 16, 24, 32};
        logic ok;
        hres = 16'd640; vres = 16'd300;
        foreach (dl[i]) begin
            longint lb, h, st;
            depth = 6'(dl[i]);
            wr(2'd0, 16'd800);
            wait_done(ok);
            lb = ref_bytes(800, dl[i]);
            h  = MEM / lb;
            chk("R6 accepted", ok, 1);
            chk("R2 line bytes", line_bytes, lb);
            chk("R3 virtual height", virt_height, h);
            chk("R6 virtual width", virt_width, 800);
            wr(2'd1, 16'd13);
            wr(2'd2, 16'd7);
            st = (lb * 7 + ref_bytes(13, dl[i])) >> 2;
            chk("R7 start after Y write", start_word, st);
            wr(2'd1, 16'd101);
            st = (lb * 7 + ref_bytes(101, dl[i])) >> 2;
            chk("R7 start after X write", start_word, st);
        end
    endtask

    task automatic t_narrow();
        logic ok;
        longint w0 = virt_width, h0 = virt_height, l0 = line_bytes;
        hres = 16'd640;
        wr(2'd0, 16'd632);
        wait_done(ok);
        chk("R4 narrow rejected", ok, 0);
        chk("R4 width kept", virt_width, w0);
        chk("R4 height kept", virt_height, h0);
        chk("R4 line kept", line_bytes, l0);
    endtask

    task automatic t_tall();
        logic ok;
        longint w0, h0, l0;
        depth = 6'd32; vres = 16'd480;
        w0 = virt_width; h0 = virt_height; l0 = line_bytes;
        wr(2'd0, 16'd800);
        wait_done(ok);
        chk("R5 tall rejected", ok, 0);
        chk("R5 width kept", virt_width, w0);
        chk("R5 height kept", virt_height, h0);
        chk("R5 line kept", line_bytes, l0);
        vres = 16'd300;
    endtask

    task automatic t_zero();
        logic ok;
        longint w0 = virt_width;
        hres = 16'd0; depth = 6'd4;
        wr(2'd0, 16'd1);
        wait_done(ok);
        chk("R9 zero line rejected", ok, 0);
        chk("R9 width kept", virt_width, w0);
        hres = 16'd640; depth = 6'd8;
    endtask

    task automatic t_stall();
        logic ok;
        longint s0;
        depth = 6'd8;
        wr(2'd0, 16'd1024);
        s0 = start_word;
        chk("R8 busy during check", busy, 1);
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'd999;
        #1;
        chk("R8 stall raised", stall, 1);
        @(negedge clk);
        wr_en = 1'b0;
        wait_done(ok);
        chk("R8 accepted after stall", ok, 1);
        chk("R8 stalled write ignored", start_word, s0);
        chk("R8 busy released", busy, 0);
        chk("R3 height width 1024", virt_height, MEM / 1024);
        wr(2'd3, 16'd55);
        chk("R2 code 3 ignored start", start_word, s0);
        chk("R2 code 3 ignored width", virt_width, 1024);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_depths();
        t_narrow();
        t_tall();
        t_zero();
        t_stall();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule